// File: doc/BRIEF.md
# Expansion Bus Port Decode Mask

This block sits between the register file of a chip's I/O system and its expansion connector. It holds two 32-bit vectors, each written and read one byte at a time through numbered control registers. The first vector holds the internal-device enables and the second holds a decode mask. While the expansion bus is switched on, a device answers only when both its enable bit and its mask bit are 1. Every I/O cycle that no internal device claims is handed on to the expansion bus.

Two internal device groups are decoded here. The first is a DMA-style port that matches on the low address byte alone. The second is a palette-extension device that matches two full 16-bit addresses. The top mask bit is a retention selector. It decides whether a soft reset or a hard reset brings the mask back to all ones, so software can keep a mask across the other reset type. Writes that come from the display-list coprocessor are never accepted.

Top module: `xbus_port_gate`

## Requirements
- R1: Register numbers 0x82..0x85 hold the enables and 0x86..0x89 hold the mask. In each group the lowest number holds bits 7:0, so 0x85 and 0x89 hold bits 31:24. A write of any byte, including reserved mask bits 30:26, reads back unchanged the following cycle. Any other register number reads 0x00.
- R2: While the asynchronous power-on reset porN is low, both the enables and the mask are all ones.
- R3: A soft reset with hard reset low sets the mask to all ones when mask bit 31 is 0. When mask bit 31 is 1 it leaves the mask unchanged.
- R4: A hard reset sets the mask to all ones when mask bit 31 is 1. When mask bit 31 is 0 it leaves the mask unchanged. If both resets are high in the same cycle, the hard-reset rule applies.
- R5: Any soft or hard reset sets all enables to ones. A register write in the same cycle as a reset is ignored.
- R6: A write with wrByCoproc high changes neither the enables nor the mask.
- R7: The DMA device (bit 25) is hit by any address whose low byte is 0x0B, whatever the high byte.
- R8: The palette device (bit 24) is hit only by the addresses 0xBF3B and 0xFF3B.
- R9: With the expansion bus on, ioClaim is high when a hit device has both its enable bit and its mask bit set.
- R10: With the expansion bus on, a valid cycle that is not claimed raises ioForward, and a claimed cycle does not.
- R11: With the expansion bus off, the mask has no effect: ioClaim is high for a hit device whose enable is set, and ioForward stays low.
- R12: With ioValid low, ioClaim and ioForward are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| rstSoft | input | 1 | Synchronous soft reset |
| rstHard | input | 1 | Synchronous hard reset |
| regSel | input | 8 | Register number for writes and readback |
| regWrData | input | 8 | Write data byte |
| regWr | input | 1 | Write strobe |
| wrByCoproc | input | 1 | Marks the write as coming from the display-list coprocessor |
| regRdData | output | 8 | Readback of the selected register |
| expBusOn | input | 1 | Expansion bus active |
| ioAddr | input | 16 | I/O cycle address |
| ioValid | input | 1 | I/O cycle present this clock |
| ioClaim | output | 1 | An internal device takes the cycle |
| ioForward | output | 1 | The cycle is passed to the expansion bus |

## Verification
The bench sets mask bit 31 both ways and applies soft, hard and simultaneous resets. A design with the retention sense inverted would restore the mask when it should keep it. A design that let the soft rule win over the hard one would restore the mask on a combined reset with bit 31 at 0. Addresses such as 0x7F3B, 0xBF3A and 0xC30B probe the decode boundaries, and a full-word or low-byte-only compare on the wrong device would mis-claim them. Toggling the bus with the mask cleared shows whether the mask leaks into decoding while the bus is off, and whether forwarding happens at all.

// File: rtl/xbg_pkg.sv
package xbg_pkg;
  localparam int BYTES  = 4;
  localparam int WIDTH  = BYTES * 8;
  localparam int DMA_BIT = 25;
  localparam int PAL_BIT = 24;
  localparam int RET_BIT = WIDTH - 1;
  localparam logic [7:0]  DMA_LOW = 8'h0B;
  localparam logic [15:0] PAL_A   = 16'hBF3B;
  localparam logic [15:0] PAL_B   = 16'hFF3B;

  typedef struct packed {
    logic [BYTES-1:0] wrEn;
    logic [BYTES-1:0] wrMask;
    logic             anyReset;
    logic             restoreMask;
  } xbgStrobe_t;
endpackage

// File: rtl/xbg_ctrl.sv
module xbg_ctrl
  import xbg_pkg::*;
#(
  parameter logic [7:0] EN_BASE   = 8'h82,
  parameter logic [7:0] MASK_BASE = 8'h86
) (
  input  logic       rstSoft,
  input  logic       rstHard,
  input  logic       regWr,
  input  logic       wrByCoproc,
  input  logic [7:0] regSel,
  input  logic       maskTop,
  output xbgStrobe_t strobe
);
  logic anyReset;
  logic wrOk;

  assign anyReset = rstSoft | rstHard;
  assign wrOk     = regWr & ~wrByCoproc & ~anyReset;

  assign strobe.anyReset    = anyReset;
  // hard reset governs; it restores when retention bit is set
  assign strobe.restoreMask = rstHard ? maskTop : (rstSoft & ~maskTop);

  for (genvar b = 0; b < BYTES; b++) begin : g_sel
    assign strobe.wrEn[b]   = wrOk & (regSel == EN_BASE + 8'(b));
    assign strobe.wrMask[b] = wrOk & (regSel == MASK_BASE + 8'(b));
  end
endmodule

// File: rtl/xbg_datapath.sv
module xbg_datapath
  import xbg_pkg::*;
#(
  parameter logic [7:0] EN_BASE   = 8'h82,
  parameter logic [7:0] MASK_BASE = 8'h86
) (
  input  logic             clk,
  input  logic             porN,
  input  xbgStrobe_t       strobe,
  input  logic [7:0]       wrData,
  input  logic [7:0]       regSel,
  input  logic             expBusOn,
  input  logic [15:0]      ioAddr,
  input  logic             ioValid,
  output logic [7:0]       rdData,
  output logic [WIDTH-1:0] enState,
  output logic [WIDTH-1:0] maskState,
  output logic             ioClaim,
  output logic             ioForward
);
  logic [WIDTH-1:0] enQ, maskQ, effMask, effEn;
  logic hitDma, hitPal;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      enQ   <= '1;
      maskQ <= '1;
    end else begin
      if (strobe.anyReset)    enQ   <= '1;
      if (strobe.restoreMask) maskQ <= '1;
      for (int b = 0; b < BYTES; b++) begin
        if (strobe.wrEn[b])   enQ[8*b +: 8]   <= wrData;
        if (strobe.wrMask[b]) maskQ[8*b +: 8] <= wrData;
      end
    end
  end

  always_comb begin
    rdData = 8'h00;
    for (int b = 0; b < BYTES; b++) begin
      if (regSel == EN_BASE + 8'(b))   rdData = enQ[8*b +: 8];
      if (regSel == MASK_BASE + 8'(b)) rdData = maskQ[8*b +: 8];
    end
  end

  assign hitDma  = ioAddr[7:0] == DMA_LOW;
  assign hitPal  = (ioAddr == PAL_A) || (ioAddr == PAL_B);
  assign effMask = expBusOn ? maskQ : '1;
  assign effEn   = enQ & effMask;

  assign ioClaim   = ioValid & ((hitDma & effEn[DMA_BIT]) | (hitPal & effEn[PAL_BIT]));
  assign ioForward = ioValid & expBusOn & ~ioClaim;

  assign enState   = enQ;
  assign maskState = maskQ;

  AST_CLAIM_FWD_EXCL: assert property (@(posedge clk) disable iff (!porN)
    !(ioClaim && ioForward)); // R10
  AST_BUSOFF_NO_FWD: assert property (@(posedge clk) disable iff (!porN)
    !expBusOn |-> !ioForward); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!porN)
    !ioValid |-> (!ioClaim && !ioForward)); // R12
endmodule

// File: rtl/xbus_port_gate.sv
module xbus_port_gate
  import xbg_pkg::*;
#(
  parameter logic [7:0] EN_BASE   = 8'h82,
  parameter logic [7:0] MASK_BASE = 8'h86
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        rstSoft,
  input  logic        rstHard,
  input  logic [7:0]  regSel,
  input  logic [7:0]  regWrData,
  input  logic        regWr,
  input  logic        wrByCoproc,
  output logic [7:0]  regRdData,
  input  logic        expBusOn,
  input  logic [15:0] ioAddr,
  input  logic        ioValid,
  output logic        ioClaim,
  output logic        ioForward
);
  xbgStrobe_t       strobe;
  logic [WIDTH-1:0] enState, maskState;

  xbg_ctrl #(.EN_BASE(EN_BASE), .MASK_BASE(MASK_BASE)) ctrl (
    .rstSoft(rstSoft), .rstHard(rstHard), .regWr(regWr),
    .wrByCoproc(wrByCoproc), .regSel(regSel),
    .maskTop(maskState[RET_BIT]), .strobe(strobe)
  );

  xbg_datapath #(.EN_BASE(EN_BASE), .MASK_BASE(MASK_BASE)) dp (
    .clk(clk), .porN(porN), .strobe(strobe), .wrData(regWrData),
    .regSel(regSel), .expBusOn(expBusOn), .ioAddr(ioAddr),
    .ioValid(ioValid), .rdData(regRdData), .enState(enState),
    .maskState(maskState), .ioClaim(ioClaim), .ioForward(ioForward)
  );

  AST_SOFT_RESTORE: assert property (@(posedge clk) disable iff (!porN)
    (rstSoft && !rstHard && !maskState[RET_BIT]) |=> (maskState == '1)); // R3
  AST_SOFT_KEEP: assert property (@(posedge clk) disable iff (!porN)
    (rstSoft && !rstHard && maskState[RET_BIT]) |=> $stable(maskState)); // R3
  AST_HARD_RESTORE: assert property (@(posedge clk) disable iff (!porN)
    (rstHard && maskState[RET_BIT]) |=> (maskState == '1)); // R4
  AST_HARD_KEEP: assert property (@(posedge clk) disable iff (!porN)
    (rstHard && !maskState[RET_BIT]) |=> $stable(maskState)); // R4
  AST_EN_RESET: assert property (@(posedge clk) disable iff (!porN)
    (rstSoft || rstHard) |=> (enState == '1)); // R5
  AST_COPROC_IGNORED: assert property (@(posedge clk) disable iff (!porN)
    (regWr && wrByCoproc && !rstSoft && !rstHard)
      |=> ($stable(enState) && $stable(maskState))); // R6
endmodule

// File: tb/tb_xbus_port_gate.sv
module tb_xbus_port_gate;
  localparam int PERIOD = 10;

  logic clk = 0, porN = 0, rstSoft = 0, rstHard = 0;
  logic [7:0] regSel = 0, regWrData = 0, regRdData;
  logic regWr = 0, wrByCoproc = 0, expBusOn = 0, ioValid = 0;
  logic [15:0] ioAddr = 0;
  logic ioClaim, ioForward;

  int checks = 0, errors = 0;
  string curReq = "R2";
  bit [31:0] mEn = '1, mMask = '1;

  always #(PERIOD/2) clk = ~clk;

  xbus_port_gate dut (.*);

  // behavioural reference
  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      mEn = '1; mMask = '1;
    end else if (rstSoft || rstHard) begin
      if (rstHard ? mMask[31] : !mMask[31]) mMask = '1;
      mEn = '1;
    end else if (regWr && !wrByCoproc) begin
      if (regSel >= 8'h82 && regSel <= 8'h85) mEn[8*(regSel-8'h82) +: 8] = regWrData;
      if (regSel >= 8'h86 && regSel <= 8'h89) mMask[8*(regSel-8'h86) +: 8] = regWrData;
    end
  end

  function automatic logic [7:0] expRd(logic [7:0] s);
    if (s >= 8'h82 && s <= 8'h85) return mEn[8*(s-8'h82) +: 8];
    if (s >= 8'h86 && s <= 8'h89) return mMask[8*(s-8'h86) +: 8];
    return 8'h00;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    begin
      bit hitD, hitP, dmaOn, palOn, eClaim, eFwd;
      string tag;
      hitD  = ioAddr[7:0] == 8'h0B;                        // R7
      hitP  = ioAddr == 16'hBF3B || ioAddr == 16'hFF3B;    // R8
      dmaOn = mEn[25] && (!expBusOn || mMask[25]);
      palOn = mEn[24] && (!expBusOn || mMask[24]);
      eClaim = ioValid && ((hitD && dmaOn) || (hitP && palOn));
      eFwd   = ioValid && expBusOn && !eClaim;
      if (!ioValid) tag = "R12";
      else if (!expBusOn) tag = "R11";
      else if (hitD) tag = "R7";
      else if (hitP) tag = "R8";
      else tag = "R9";
      chk(curReq, "readback", {24'h0, regRdData}, {24'h0, expRd(regSel)});
      chk(tag, "ioClaim", {31'h0, ioClaim}, {31'h0, eClaim});
      chk(ioValid && expBusOn ? "R10" : tag, "ioForward", {31'h0, ioForward}, {31'h0, eFwd});
    end
  end

  task automatic wr(logic [7:0] s, logic [7:0] d, logic cp = 0);
    @(negedge clk); regSel = s; regWrData = d; regWr = 1; wrByCoproc = cp;
    @(negedge clk); regWr = 0; wrByCoproc = 0;
  endtask

  task automatic rd(logic [7:0] s);
    @(negedge clk); regSel = s;
  endtask

  task automatic rst(logic s, logic h);
    @(negedge clk); rstSoft = s; rstHard = h;
    @(negedge clk); rstSoft = 0; rstHard = 0;
  endtask

  task automatic io(logic [15:0] a, logic bus);
    @(negedge clk); ioAddr = a; ioValid = 1; expBusOn = bus;
    @(negedge clk); ioValid = 0;
  endtask

  task automatic scan(logic bus);
    logic [15:0] addrs[8] = '{16'h000B, 16'hC30B, 16'hBF3B, 16'hFF3B,
                              16'h7F3B, 16'hBF3A, 16'h1234, 16'hFF0B};
    foreach (addrs[i]) io(addrs[i], bus);
  endtask

  initial begin
    #(PERIOD*100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R2: power-on state
    rd(8'h89); rd(8'h82);
    @(negedge clk); porN = 1;
    // R1: write and read every register, plus unmapped numbers
    curReq = "R1";
    for (int i = 0; i < 8; i++) wr(8'h82 + 8'(i), 8'h5A ^ 8'(i * 37));
    wr(8'h89, 8'h7C);
    for (int i = 0; i < 8; i++) rd(8'h82 + 8'(i));
    rd(8'h10); rd(8'h81); rd(8'h8A);
    // R6: coprocessor writes ignored
    curReq = "R6";
    wr(8'h86, 8'h00, 1); rd(8'h86);
    wr(8'h84, 8'h00, 1); rd(8'h84);
    // R3: soft reset restores when bit 31 is 0, keeps when it is 1
    curReq = "R3";
    wr(8'h89, 8'h7F); wr(8'h86, 8'h00);
    rst(1, 0); rd(8'h89); rd(8'h86);
    wr(8'h89, 8'h80); wr(8'h86, 8'h12);
    rst(1, 0); rd(8'h89); rd(8'h86);
    // R5: enables back to ones, write during reset ignored
    curReq = "R5";
    wr(8'h83, 8'h00);
    @(negedge clk); rstSoft = 1; regSel = 8'h87; regWrData = 8'h33; regWr = 1;
    @(negedge clk); rstSoft = 0; regWr = 0;
    rd(8'h83); rd(8'h87);
    // R4: hard reset rules, and hard governs when both are high
    curReq = "R4";
    wr(8'h89, 8'h81); wr(8'h88, 8'h00);
    rst(0, 1); rd(8'h89); rd(8'h88);
    wr(8'h89, 8'h01); wr(8'h88, 8'h44);
    rst(0, 1); rd(8'h89); rd(8'h88);
    rst(1, 1); rd(8'h89); rd(8'h88);
    // R7 R8 R9 R10 R11: decode with each enable/mask pairing, bus on and off
    curReq = "R1";
    for (int c = 0; c < 16; c++) begin
      wr(8'h85, {6'h00, 2'(c)});
      wr(8'h89, {6'h00, 2'(c >> 2)});
      scan(1); scan(0);
    end
    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      regSel    = 8'h80 + 8'($urandom_range(0, 11));
      regWrData = 8'($urandom);
      regWr     = $urandom_range(0, 3) == 0;
      wrByCoproc = $urandom_range(0, 3) == 0;
      rstSoft   = $urandom_range(0, 40) == 0;
      rstHard   = $urandom_range(0, 40) == 0;
      expBusOn  = 1'($urandom);
      ioValid   = $urandom_range(0, 3) != 0;
      case ($urandom_range(0, 3))
        0: ioAddr = {8'($urandom), 8'h0B};
        1: ioAddr = $urandom_range(0, 1) ? 16'hBF3B : 16'hFF3B;
        2: ioAddr = {8'($urandom), 8'h3B};
        default: ioAddr = 16'($urandom);
      endcase
    end
    @(negedge clk); regWr = 0; rstSoft = 0; rstHard = 0; ioValid = 0;
    @(negedge clk); @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule